// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Controller

This block is the slave end of a three-wire serial memory link. It has a chip select, a serial clock, serial data in and serial data out, and it fronts a byte-wide storage array of 2^ADDR_W words. The block samples the serial pins on its own system clock. It picks out the start bit, the opcode, the address and, where present, the data byte. It then performs a read, a single-byte write, a single-byte erase, a fill of every word with one byte, a clear of the whole array, or a change to the write-protect latch.

Every command that changes the array starts a self-timed busy period of BUSY_CYCLES system clocks. If the host raises chip select again during this period, the block drives the data pin low while the operation runs and drives it high once it has finished. Writes are protected after reset. The host must unlock them with a command. A write can be made over any old content without erasing it first.

Top module: `ee3w_ctrl`

## Requirements
- R1: After reset, do_oe_o is 0, writes are locked and every word of the array reads FFh.
- R2: Bits are sampled on rising serial-clock edges while chip select is high. Zeros before the first 1 are skipped. That 1 is the start bit. It is followed by a 2-bit opcode and then ADDR_W address bits, MSB first in both fields.
- R3: Opcode 10 is a read. After the rising edge that takes the last address bit, do_oe_o goes to 1 and do_o shows a dummy 0. Each of the next 8 rising edges presents D7 down to D0. The 9th such edge turns the output off.
- R4: Opcode 01 is a write. It takes 8 data bits (MSB first) after the address and stores them at that address when chip select falls. The old content does not need to be erased first.
- R5: Opcode 11 is an erase. It sets the addressed word to FFh.
- R6: Opcode 00 with address bits [7:6]=11 unlocks writes. Opcode 00 with [7:6]=00 locks them. The other address bits are ignored.
- R7: Opcode 00 with [7:6]=10 sets every word to FFh. Opcode 00 with [7:6]=01, followed by a data byte, writes that byte to every word.
- R8: While writes are locked, write, erase, clear-all and fill-all leave the array unchanged and start no busy period.
- R9: A command acts only when chip select falls after the command's complete bit count. A command cut short by chip select falling has no effect.
- R10: An accepted array-changing command keeps the block busy for BUSY_CYCLES clocks, starting from the clock that sees chip select fall.
- R11: If chip select rises while the block is busy, do_oe_o is 1 until chip select falls. do_o is 0 while the block is busy and 1 once it is done.
- R12: Serial bits sent while busy, or later in the same chip-select period as a status read, are ignored.
- R13: do_oe_o is 0 whenever chip select is low, and whenever no read output or status phase is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; all serial pins are sampled on it |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial data from the host |
| do_o | output | 1 | Serial data / ready status to the host |
| do_oe_o | output | 1 | Output enable for do_o (0 means high impedance) |

## Verification
The hardest state to reach from the pins is a status phase during a busy period in which the host also keeps clocking in a new command. This needs a write that is accepted and then a chip-select rise within a few clocks of its fall. The bench does exactly that. It then clocks a complete write to another address and reads that address afterwards, to show the command was dropped. A second case puts chip select high again one clock after the fall and counts status-low samples against BUSY_CYCLES. A behavioural model compares both outputs on every clock, so any skew in the busy window or the read bit order shows up.

// File: rtl/ee3w_pkg.sv
package ee3w_pkg;
  localparam int OPC_W = 2;

  typedef enum logic [1:0] {
    OPC_SYS   = 2'b00,
    OPC_WRITE = 2'b01,
    OPC_READ  = 2'b10,
    OPC_ERASE = 2'b11
  } opc_e;

  // selector in the top two address bits when opcode is OPC_SYS
  typedef enum logic [1:0] {
    SUB_LOCK   = 2'b00,
    SUB_FILL   = 2'b01,
    SUB_CLEAR  = 2'b10,
    SUB_UNLOCK = 2'b11
  } sub_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_READ, ST_DONE
  } st_e;

  typedef enum logic [2:0] {
    ACT_NONE, ACT_UNLOCK, ACT_LOCK, ACT_WRITE, ACT_ERASE, ACT_FILL, ACT_CLEAR
  } act_e;
endpackage

// File: rtl/ee3w_pin_edge.sv
module ee3w_pin_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  output logic cs_q_o,
  output logic cs_rise_o,
  output logic cs_fall_o,
  output logic sk_rise_o
);
  logic cs_q, sk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q <= 1'b0;
      sk_q <= 1'b0;
    end else begin
      cs_q <= cs_i;
      sk_q <= sk_i;
    end
  end

  assign cs_q_o    = cs_q;
  assign cs_rise_o = cs_i & ~cs_q;
  assign cs_fall_o = ~cs_i & cs_q;
  // shifting only inside a steady select window
  assign sk_rise_o = cs_i & cs_q & sk_i & ~sk_q;
endmodule

// File: rtl/ee3w_shifter.sv
module ee3w_shifter
  import ee3w_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              di_i,
  input  logic              sk_rise_i,
  input  logic              cs_fall_i,
  input  logic              hold_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output act_e              act_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              rd_active_o,
  output logic              rd_bit_o
);
  localparam int MAXF = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int CNT_W = $clog2(MAXF + 1);

  st_e               st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [OPC_W-1:0]  opc_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W:0]   rd_sh_q;
  logic [ADDR_W-1:0] addr_full;
  logic              shift_en, needs_data;

  assign addr_full  = {addr_q[ADDR_W-2:0], di_i};
  assign rd_addr_o  = addr_full;
  assign shift_en   = sk_rise_i & ~hold_i;
  assign needs_data = (opc_q == OPC_WRITE) ||
                      ((opc_q == OPC_SYS) && (addr_full[ADDR_W-1 -: 2] == SUB_FILL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      opc_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      rd_sh_q <= '0;
    end else if (!cs_i) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (shift_en) begin
      case (st_q)
        ST_IDLE: begin
          if (di_i) begin
            st_q  <= ST_OPC;
            cnt_q <= '0;
          end
        end
        ST_OPC: begin
          opc_q <= {opc_q[OPC_W-2:0], di_i};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(OPC_W - 1)) begin
            st_q  <= ST_ADDR;
            cnt_q <= '0;
          end
        end
        ST_ADDR: begin
          addr_q <= addr_full;
          cnt_q  <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(ADDR_W - 1)) begin
            cnt_q <= '0;
            if (opc_q == OPC_READ) begin
              st_q    <= ST_READ;
              rd_sh_q <= {1'b0, rd_data_i};
            end else if (needs_data) begin
              st_q <= ST_DATA;
            end else begin
              st_q <= ST_DONE;
            end
          end
        end
        ST_DATA: begin
          data_q <= {data_q[DATA_W-2:0], di_i};
          cnt_q  <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(DATA_W - 1)) st_q <= ST_DONE;
        end
        ST_READ: begin
          rd_sh_q <= {rd_sh_q[DATA_W-1:0], 1'b0};
          cnt_q   <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(DATA_W)) st_q <= ST_DONE;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    act_o = ACT_NONE;
    if (cs_fall_i && st_q == ST_DONE) begin
      case (opc_q)
        OPC_WRITE: act_o = ACT_WRITE;
        OPC_ERASE: act_o = ACT_ERASE;
        OPC_SYS: begin
          case (addr_q[ADDR_W-1 -: 2])
            SUB_UNLOCK: act_o = ACT_UNLOCK;
            SUB_LOCK:   act_o = ACT_LOCK;
            SUB_CLEAR:  act_o = ACT_CLEAR;
            default:    act_o = ACT_FILL;
          endcase
        end
        default: act_o = ACT_NONE;
      endcase
    end
  end

  assign addr_o      = addr_q;
  assign data_o      = data_q;
  assign rd_active_o = (st_q == ST_READ);
  assign rd_bit_o    = rd_sh_q[DATA_W];

  AST_READ_DUMMY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_active_o) |-> !rd_bit_o); // R3
  AST_HOLD_FREEZES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && cs_i) |=> $stable(st_q)); // R12
  AST_ACT_NEEDS_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o != ACT_NONE) |=> (st_q == ST_IDLE)); // R9
endmodule

// File: rtl/ee3w_busy_timer.sv
module ee3w_busy_timer #(
  parameter int BUSY_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (start_i)          cnt_q <= CW'(BUSY_CYCLES);
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  AST_START_WHEN_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o); // R12
  AST_BUSY_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o); // R10
  AST_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !start_i) |=> (cnt_q == $past(cnt_q) - CW'(1))); // R10
endmodule

// File: rtl/ee3w_regfile.sv
module ee3w_regfile #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              fill_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                         mem[i] <= '1;
      else if (fill_i || (wr_i && waddr_i == ADDR_W'(i)))  mem[i] <= wdata_i;
    end
  end

  assign rd_data_o = mem[raddr_i];

  AST_FILL_COVERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |=> (mem[0] == $past(wdata_i) && mem[DEPTH-1] == $past(wdata_i))); // R7
  AST_SINGLE_WRITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fill_i && wr_i)); // R7
endmodule

// File: rtl/ee3w_ctrl.sv
module ee3w_ctrl
  import ee3w_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int BUSY_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o,
  output logic do_oe_o
);
  logic              cs_q, cs_rise, cs_fall, sk_rise;
  logic              busy, hold, we_q, stat_q;
  logic              wr, fill, start;
  act_e              act;
  logic [ADDR_W-1:0] addr, rd_addr;
  logic [DATA_W-1:0] data, wdata, rd_data;
  logic              rd_active, rd_bit;

  ee3w_pin_edge u_pins (
    .clk_i, .rst_ni, .cs_i, .sk_i,
    .cs_q_o(cs_q), .cs_rise_o(cs_rise), .cs_fall_o(cs_fall), .sk_rise_o(sk_rise)
  );

  ee3w_shifter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni, .cs_i, .di_i,
    .sk_rise_i(sk_rise), .cs_fall_i(cs_fall), .hold_i(hold),
    .rd_data_i(rd_data), .act_o(act), .addr_o(addr), .data_o(data),
    .rd_addr_o(rd_addr), .rd_active_o(rd_active), .rd_bit_o(rd_bit)
  );

  ee3w_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk_i, .rst_ni, .start_i(start), .busy_o(busy)
  );

  ee3w_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i, .rst_ni, .wr_i(wr), .fill_i(fill), .waddr_i(addr),
    .wdata_i(wdata), .raddr_i(rd_addr), .rd_data_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 we_q <= 1'b0;
    else if (act == ACT_UNLOCK)  we_q <= 1'b1;
    else if (act == ACT_LOCK)    we_q <= 1'b0;
  end

  // status phase: select reasserted during a self-timed cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                stat_q <= 1'b0;
    else if (!cs_i)             stat_q <= 1'b0;
    else if (cs_rise && busy)   stat_q <= 1'b1;
  end

  assign hold  = busy | stat_q;
  assign wr    = we_q & (act == ACT_WRITE || act == ACT_ERASE);
  assign fill  = we_q & (act == ACT_FILL || act == ACT_CLEAR);
  assign wdata = (act == ACT_ERASE || act == ACT_CLEAR) ? '1 : data;
  assign start = wr | fill;

  assign do_oe_o = cs_q & (stat_q | rd_active);
  assign do_o    = stat_q ? ~busy : rd_bit;

  AST_OE_OFF_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> !do_oe_o); // R13
  AST_LOCKED_NO_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((act == ACT_WRITE || act == ACT_ERASE || act == ACT_FILL || act == ACT_CLEAR) && !we_q)
      |=> !busy); // R8
  AST_UNLOCK_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act == ACT_UNLOCK) |=> we_q); // R6
  AST_STATUS_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q && cs_i) |=> stat_q); // R11
endmodule

// File: tb/tb_ee3w_ctrl.sv
module tb_ee3w_ctrl;
  localparam int BUSY = 20;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_w, oe_w;

  always #2 clk = ~clk;

  ee3w_ctrl #(.ADDR_W(8), .DATA_W(8), .BUSY_CYCLES(BUSY)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .do_o(do_w), .do_oe_o(oe_w)
  );

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit mon_en = 0, finished = 0;

  // behavioural reference
  int mem_m [256];
  bit we_m = 0, stat_m = 0, prev_cs = 0, prev_sk = 0;
  int busy_m = 0;
  bit started_m = 0, reading_m = 0, fin_m = 0;
  int rdcnt_m = 0, rdval_m = 0, op_m = 0, addr_m = 0, data_m = 0;
  bit bits_q [$];
  bit exp_oe = 0, exp_do = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int fld(int lo, int n);
    int v = 0;
    for (int i = 0; i < n; i++) v = (v << 1) | int'(bits_q[lo + i]);
    return v;
  endfunction

  function automatic void seq_clear();
    started_m = 0; reading_m = 0; fin_m = 0; rdcnt_m = 0;
    bits_q.delete();
  endfunction

  function automatic void m_exec();
    if (!fin_m) return;
    case (op_m)
      0: case (addr_m >> 6)
           3: we_m = 1;
           0: we_m = 0;
           2: if (we_m) begin for (int i = 0; i < 256; i++) mem_m[i] = 255; busy_m = BUSY; end
           default: if (we_m) begin for (int i = 0; i < 256; i++) mem_m[i] = data_m; busy_m = BUSY; end
         endcase
      1: if (we_m) begin mem_m[addr_m] = data_m; busy_m = BUSY; end
      3: if (we_m) begin mem_m[addr_m] = 255; busy_m = BUSY; end
      default: ;
    endcase
  endfunction

  function automatic void m_shift(bit b);
    if (!started_m) begin
      if (b) started_m = 1;
    end else if (reading_m) begin
      rdcnt_m++;
      if (rdcnt_m == 9) begin reading_m = 0; fin_m = 1; end
    end else if (!fin_m) begin
      bits_q.push_back(b);
      if (bits_q.size() == 10) begin
        op_m = fld(0, 2);
        addr_m = fld(2, 8);
        if (op_m == 2) begin
          reading_m = 1; rdcnt_m = 0; rdval_m = mem_m[addr_m];
        end else if (!(op_m == 1 || (op_m == 0 && (addr_m >> 6) == 1))) begin
          fin_m = 1;
        end
      end else if (bits_q.size() == 18) begin
        data_m = fld(10, 8);
        fin_m = 1;
      end
    end
  endfunction

  always @(negedge clk) begin
    if (mon_en) begin
      int busy_pre;
      n_chk++;
      if (oe_w !== exp_oe || (exp_oe && do_w !== exp_do)) begin
        n_fail++;
        $display("FAIL %s per-cycle: actual oe=%b do=%b expected oe=%b do=%b",
                 cur_req, oe_w, do_w, exp_oe, exp_do);
      end
      busy_pre = busy_m;
      if (busy_m > 0) busy_m--;
      if (prev_cs && !cs) begin
        m_exec();
        seq_clear();
        stat_m = 0;
      end else if (!prev_cs && cs) begin
        if (busy_pre > 0) stat_m = 1;
      end else if (cs && prev_cs && sk && !prev_sk && busy_pre == 0 && !stat_m) begin
        m_shift(di);
      end
      if (!cs) begin stat_m = 0; seq_clear(); end
      prev_cs = cs;
      prev_sk = sk;
      exp_oe = cs && (stat_m || reading_m);
      exp_do = stat_m ? (busy_m == 0) :
               (rdcnt_m == 0 ? 1'b0 : 1'((rdval_m >> (8 - rdcnt_m)) & 1));
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sel(bit v);
    tick(1);
    cs = v;
    if (!v) sk = 1'b0;
  endtask

  task automatic bit_out(bit b);
    sk = 1'b0; di = b; tick(2);
    sk = 1'b1; tick(2);
  endtask

  task automatic send(int v, int n);
    for (int i = n - 1; i >= 0; i--) bit_out(1'((v >> i) & 1));
  endtask

  task automatic cmd(int v, int n);
    sel(1); send(v, n); sel(0); tick(1);
  endtask

  function automatic int w_write(int a, int d); return (3'b101 << 16) | (a << 8) | d; endfunction
  function automatic int w_erase(int a);        return (3'b111 << 8) | a; endfunction
  function automatic int w_sys(int a);          return (3'b100 << 8) | a; endfunction

  task automatic read_at(int a, output int val, input string req);
    sel(1);
    send((3'b110 << 8) | a, 11);
    chk(oe_w && !do_w, "R3", "dummy bit", {oe_w, do_w}, 2);
    val = 0;
    for (int i = 0; i < 8; i++) begin
      sk = 1'b0; tick(2); sk = 1'b1; tick(2);
      val = (val << 1) | int'(do_w);
    end
    sk = 1'b0; tick(2); sk = 1'b1; tick(2);
    chk(!oe_w, "R13", "oe after read", oe_w, 0);
    sel(0); tick(1);
    chk(val == mem_m[a], req, "read data", val, mem_m[a]);
  endtask

  task automatic expect_read(int a, int e, string req);
    int v;
    read_at(a, v, req);
    chk(v == e, req, "read value", v, e);
  endtask

  initial begin
    int cnt;
    for (int i = 0; i < 256; i++) mem_m[i] = 255;
    tick(3);
    chk(!oe_w, "R1", "oe in reset", oe_w, 0);
    rst_n = 1'b1;
    mon_en = 1;
    tick(2);

    cur_req = "R1";
    expect_read(8'h05, 8'hFF, "R1");

    cur_req = "R8";
    cmd(w_write(8'h20, 8'h77), 19);
    sel(1); tick(2);
    chk(!oe_w, "R8", "no busy while locked", oe_w, 0);
    sel(0); tick(1);
    expect_read(8'h20, 8'hFF, "R8");

    cur_req = "R2";
    sel(1); send(0, 3); send(w_sys(8'hC5), 11); sel(0); tick(1);

    cur_req = "R11";
    cmd(w_write(8'h12, 8'h3C), 19);
    sel(1); tick(2);
    chk(oe_w && !do_w, "R11", "status low while busy", {oe_w, do_w}, 2);
    cur_req = "R12";
    send(w_write(8'h47, 8'h00), 19);
    tick(BUSY);
    chk(oe_w && do_w, "R11", "status high when done", {oe_w, do_w}, 3);
    sel(0); tick(1);
    expect_read(8'h47, 8'hFF, "R12");
    cur_req = "R4";
    expect_read(8'h12, 8'h3C, "R4");

    cmd(w_write(8'h12, 8'hA5), 19); tick(BUSY + 2);
    expect_read(8'h12, 8'hA5, "R4");

    cur_req = "R5";
    cmd(w_erase(8'h12), 11); tick(BUSY + 2);
    expect_read(8'h12, 8'hFF, "R5");

    cur_req = "R9";
    cmd(w_write(8'h30, 8'h00) >> 13, 6);
    sel(1); tick(2);
    chk(!oe_w, "R9", "short command ignored", oe_w, 0);
    sel(0); tick(1);
    cmd(w_write(8'h30, 8'h66) >> 1, 18);
    expect_read(8'h30, 8'hFF, "R9");

    cur_req = "R10";
    sel(1); send(w_write(8'h31, 8'h0F), 19); sel(0);
    sel(1);
    cnt = 0;
    for (int i = 0; i < 2 * BUSY; i++) begin
      tick(1);
      if (oe_w && !do_w) cnt++;
    end
    chk(cnt == BUSY - 1, "R10", "busy samples", cnt, BUSY - 1);
    sel(0); tick(1);

    cur_req = "R7";
    cmd(w_sys(8'h40) << 8 | 8'h5A, 19); tick(BUSY + 2);
    expect_read(8'h00, 8'h5A, "R7");
    expect_read(8'hFF, 8'h5A, "R7");
    cmd(w_sys(8'h80), 11); tick(BUSY + 2);
    expect_read(8'h80, 8'hFF, "R7");

    cur_req = "R6";
    cmd(w_sys(8'h3F), 11);
    cur_req = "R8";
    cmd(w_sys(8'h40) << 8 | 8'h11, 19);
    sel(1); tick(2);
    chk(!oe_w, "R8", "fill while locked", oe_w, 0);
    sel(0); tick(1);
    cmd(w_erase(8'h31), 11);
    expect_read(8'h31, 8'hFF, "R6");
    expect_read(8'h44, 8'hFF, "R8");

    cur_req = "R13";
    sel(1); send(0, 4); tick(2);
    chk(!oe_w, "R13", "oe idle while selected", oe_w, 0);
    sel(0); tick(4);

    mon_en = 0;
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule